// File: doc/BRIEF.md
# GPIO Bank Controller with Set/Clear Output Registers

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins. Pins are grouped into 32-bit banks. Software talks to it over a single-cycle register port: an address, a write strobe with write data, and a read strobe whose data comes back on the following clock. On the pin side it drives an output value and an output enable for every pin and samples every pin's input.

Each bank owns one word in each of four register blocks: a read-only input level word, a read/write direction word, a write-only word that sets output latch bits and a write-only word that clears them. Because the latch is only changed through the set and clear words, two agents can each update their own pins without a read-modify-write sequence. A read-only configuration word at offset zero reports the pin count and the bank count. Pin inputs are passed through a two-stage synchroniser before software can see them.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, every output enable is 0 (all pins are inputs), every output latch bit is 0 and `rd_data` is 0.
- R2: A pin `p` is held in the word at block base + 4 × (p / 32), at bit p mod 32. The block bases are 0x004 (level), 0x01C (direction), 0x034 (set) and 0x04C (clear), each with one word per bank.
- R3: Writing the set word drives high each output latch bit written as 1; bits written as 0 keep their value.
- R4: Writing the clear word drives low each output latch bit written as 1; bits written as 0 keep their value. If a set and a clear of the same bit were applied together, the clear wins.
- R5: The direction word is read/write; a 1 makes the pin an output (`pin_oe` high) and a 0 makes it an input.
- R6: The level word returns the pin inputs through a two-flop synchroniser: after `pin_in` changes before rising edge k, a read whose strobe is sampled at edge k or k+1 returns the old value and one sampled at edge k+2 returns the new value.
- R7: Reads of the set and clear words return 0, and writes to the level word change nothing.
- R8: The word at offset 0x000 is read-only and reads as the pin count in bits [15:0], the bank count in bits [23:16] and 0 in bits [31:24].
- R9: `rd_data` is registered: it carries the addressed word on the cycle after `rd_en` is sampled high and is 0 after any cycle in which `rd_en` is low.
- R10: Addresses outside the four blocks and the configuration word, addresses past the last bank of a block, and addresses not aligned to 4 bytes read as 0 and writes to them change no output.
- R11: In a last bank that is only partly populated, bits with no pin read as 0 and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| pin_in | input | NUM_PINS | Pin input values (asynchronous) |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (1 = pin driven) |

## Verification
On every cycle the assertions check that a set write never lowers a latch bit and a clear write never raises one, that outputs only move on writes to a mapped register, that an idle read port returns zero, that the configuration word and the write-only words read correctly, and that the pins leave reset as inputs with a zero latch. The exact bit landing for a given pin number, the two-cycle synchroniser delay, the zeroed bits of the partial last bank and the full read-back of the direction word are only shown by the bench's scenarios, where a behavioural model is compared with the outputs each clock.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int MAX_BANKS = 6;

    localparam logic [ADDR_W-1:0] OFS_CFG   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_SET   = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h04C;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CFG,
        REG_LEVEL,
        REG_DIR,
        REG_SET,
        REG_CLR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] bank;
    } reg_sel_t;

    typedef struct packed {
        logic dir_we;
        logic set_we;
        logic clr_we;
    } bank_wr_t;

    // Number of populated pins in bank b.
    function automatic int bank_width(input int npins, input int b);
        int left;
        left = npins - b * WORD_W;
        return (left > WORD_W) ? WORD_W : left;
    endfunction

    // Address falls on a word of a per-bank block starting at base.
    function automatic logic in_block(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base,
                                      input int nbanks);
        return (a >= base) && (a[1:0] == 2'b00) &&
               (((a - base) >> 2) < ADDR_W'(nbanks));
    endfunction

    function automatic logic [2:0] bank_in(input logic [ADDR_W-1:0] a,
                                           input logic [ADDR_W-1:0] base);
        return 3'((a - base) >> 2);
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int nbanks);
        reg_sel_t s;
        s.kind = REG_NONE;
        s.bank = '0;
        if (a == OFS_CFG) begin
            s.kind = REG_CFG;
        end else if (in_block(a, OFS_LEVEL, nbanks)) begin
            s.kind = REG_LEVEL;
            s.bank = bank_in(a, OFS_LEVEL);
        end else if (in_block(a, OFS_DIR, nbanks)) begin
            s.kind = REG_DIR;
            s.bank = bank_in(a, OFS_DIR);
        end else if (in_block(a, OFS_SET, nbanks)) begin
            s.kind = REG_SET;
            s.bank = bank_in(a, OFS_SET);
        end else if (in_block(a, OFS_CLR, nbanks)) begin
            s.kind = REG_CLR;
            s.bank = bank_in(a, OFS_CLR);
        end
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_word(input int npins, input int nbanks);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[15:0]  = 16'(npins);
        w[23:16] = 8'(nbanks);
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_BANKS = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    always_comb begin
        sel = decode_addr(addr, NUM_BANKS);
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_setclr_pkg::*;
#(
    parameter int BW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bank_wr_t      we,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] dir_q,
    output logic [BW-1:0] lat_q
);

    logic [BW-1:0] set_m;
    logic [BW-1:0] clr_m;

    always_comb begin
        set_m = we.set_we ? wdata : '0;
        clr_m = we.clr_we ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lat_q <= '0;
        end else begin
            if (we.dir_we) begin
                dir_q <= wdata;
            end
            // Clear is applied after set, so it wins on a shared bit.
            lat_q <= (lat_q | set_m) & ~clr_m;
        end
    end

endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam logic [WORD_W-1:0] CFG_WORD = cfg_word(NUM_PINS, NUM_BANKS);

    reg_sel_t            sel;
    logic [NUM_PINS-1:0] pin_sync;
    logic [WORD_W-1:0]   lvl_w [NUM_BANKS];
    logic [WORD_W-1:0]   dir_w [NUM_BANKS];
    logic [WORD_W-1:0]   rd_next;

    gpio_in_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_addr_decode #(
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = bank_width(NUM_PINS, b);

        bank_wr_t      we;
        logic [BW-1:0] dir_q;
        logic [BW-1:0] lat_q;

        always_comb begin
            we.dir_we = wr_en && (sel.kind == REG_DIR) && (sel.bank == 3'(b));
            we.set_we = wr_en && (sel.kind == REG_SET) && (sel.bank == 3'(b));
            we.clr_we = wr_en && (sel.kind == REG_CLR) && (sel.bank == 3'(b));
        end

        gpio_bank_regs #(
            .BW (BW)
        ) u_regs (
            .clk   (clk),
            .rst   (rst),
            .we    (we),
            .wdata (wr_data[BW-1:0]),
            .dir_q (dir_q),
            .lat_q (lat_q)
        );

        assign pin_out[b*WORD_W +: BW] = lat_q;
        assign pin_oe[b*WORD_W +: BW]  = dir_q;
        assign lvl_w[b] = WORD_W'(pin_sync[b*WORD_W +: BW]);
        assign dir_w[b] = WORD_W'(dir_q);
    end

    always_comb begin
        rd_next = '0;
        case (sel.kind)
            REG_CFG: rd_next = CFG_WORD;
            REG_LEVEL: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel.bank == 3'(b)) rd_next = lvl_w[b];
                end
            end
            REG_DIR: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel.bank == 3'(b)) rd_next = dir_w[b];
                end
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? rd_next : '0;
        end
    end

endmodule

// File: rtl/gpio_setclr_ctrl_chk.sv
module gpio_setclr_ctrl_chk
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_PINS = 48
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic [WORD_W-1:0]   wr_data,
    input logic                rd_en,
    input logic [WORD_W-1:0]   rd_data,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);

    localparam int NB = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam logic [WORD_W-1:0] EXP_CFG = {8'h00, 8'(NB), 16'(NUM_PINS)};

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
        return (a >= base) && (a < base + ADDR_W'(4 * NB)) && (a[1:0] == 2'b00);
    endfunction

    logic set_acc, clr_acc, dir_acc, live_wr;
    always_comb begin
        set_acc = hit(addr, OFS_SET);
        clr_acc = hit(addr, OFS_CLR);
        dir_acc = hit(addr, OFS_DIR);
        live_wr = wr_en && (set_acc || clr_acc || dir_acc);
    end

    logic unused_ok;
    assign unused_ok = ^{wr_data, pin_in};

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $fell(rst) |-> (pin_out == '0) && (pin_oe == '0) && (rd_data == '0)); // R1

    AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && set_acc) |=> (($past(pin_out) & ~pin_out) == '0)); // R3

    AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && clr_acc) |=> ((~$past(pin_out) & pin_out) == '0)); // R4

    AST_OE_ONLY_DIR: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dir_acc) |=> $stable(pin_oe)); // R5

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (set_acc || clr_acc)) |=> (rd_data == '0)); // R7

    AST_CFG_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == OFS_CFG)) |=> (rd_data == EXP_CFG)); // R8

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0)); // R9

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !live_wr |=> $stable(pin_out) && $stable(pin_oe)); // R10

endmodule

bind gpio_setclr_ctrl gpio_setclr_ctrl_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpio_setclr_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_setclr_ctrl_tb;

    localparam int NP = 48;
    localparam int NB = 2;
    localparam logic [31:0] CFG_EXP = 32'h0002_0030;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio_setclr_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // ---------------- behavioural reference ----------------
    logic [NP-1:0] m_dir, m_lat, m_lvl;
    logic [31:0]   m_rd;
    logic [NP-1:0] lvl_q[$];

    function automatic logic [31:0] word_of(input logic [NP-1:0] v, input int bank);
        logic [63:0] w;
        w = 64'(v);
        return w[bank*32 +: 32];
    endfunction

    function automatic int bank_of(input int a, input int base);
        if (a % 4 != 0) return -1;
        if (a < base || a >= base + 4 * NB) return -1;
        return (a - base) / 4;
    endfunction

    always @(posedge clk) begin
        int a, bk;
        started = 1;
        if (rst) begin
            m_dir = '0; m_lat = '0; m_rd = '0;
            lvl_q = {};
            lvl_q.push_back('0);
            lvl_q.push_back('0);
        end else begin
            a = int'(addr);
            m_lvl = lvl_q.pop_front();
            m_rd = '0;
            if (rd_en) begin
                if (a == 0) m_rd = CFG_EXP;
                else if (bank_of(a, 'h004) >= 0) m_rd = word_of(m_lvl, bank_of(a, 'h004));
                else if (bank_of(a, 'h01C) >= 0) m_rd = word_of(m_dir, bank_of(a, 'h01C));
            end
            if (wr_en) begin
                for (int i = 0; i < NP; i++) begin
                    bk = i / 32;
                    if (bank_of(a, 'h01C) == bk) m_dir[i] = wr_data[i % 32];
                    if (bank_of(a, 'h034) == bk && wr_data[i % 32]) m_lat[i] = 1'b1;
                    if (bank_of(a, 'h04C) == bk && wr_data[i % 32]) m_lat[i] = 1'b0;
                end
            end
            lvl_q.push_back(pin_in);
        end
    end

    // Compare every clock, away from the rising edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            n_cmp += 3;
            if (pin_out !== m_lat) begin
                n_bad++;
                $display("FAIL R3 R4 pin_out: got %h expected %h", pin_out, m_lat);
            end
            if (pin_oe !== m_dir) begin
                n_bad++;
                $display("FAIL R5 pin_oe: got %h expected %h", pin_oe, m_dir);
            end
            if (rd_data !== m_rd) begin
                n_bad++;
                $display("FAIL R2 R9 rd_data: got %h expected %h", rd_data, m_rd);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        check("R1 pin_oe in reset", 64'(pin_oe), 64'h0);
        check("R1 pin_out in reset", 64'(pin_out), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pin_oe after reset", 64'(pin_oe), 64'h0);
        check("R1 rd_data after reset", 64'(rd_data), 64'h0);
        bus_read(12'h01C, d);
        check("R1 direction word after reset", 64'(d), 64'h0);

        bus_read(12'h000, d);
        check("R8 configuration word", 64'(d), 64'(CFG_EXP));

        bus_write(12'h01C, 32'h0000_FF0F);
        bus_read(12'h01C, d);
        check("R5 direction read-back", 64'(d), 64'h0000_FF0F);
        check("R5 pin_oe bank0", 64'(pin_oe[31:0]), 64'h0000_FF0F);

        bus_write(12'h034, 32'h8000_0011);
        check("R3 set bank0", 64'(pin_out[31:0]), 64'h8000_0011);
        bus_write(12'h034, 32'h0000_0100);
        check("R3 zeros keep value", 64'(pin_out[31:0]), 64'h8000_0111);
        bus_write(12'h04C, 32'h0000_0011);
        check("R4 clear bank0", 64'(pin_out[31:0]), 64'h8000_0100);

        bus_write(12'h038, 32'hFFFF_FFFF);
        check("R2 set bank1", 64'(pin_out[47:32]), 64'hFFFF);
        bus_write(12'h050, 32'h0000_0100);
        check("R2 clear pin 40", 64'(pin_out[47:32]), 64'hFEFF);
        bus_read(12'h038, d);
        check("R7 set word reads zero", 64'(d), 64'h0);
        bus_read(12'h04C, d);
        check("R7 clear word reads zero", 64'(d), 64'h0);

        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_read(12'h020, d);
        check("R11 unpopulated direction bits", 64'(d), 64'h0000_FFFF);

        bus_write(12'h054, 32'hFFFF_FFFF);
        bus_write(12'h03C, 32'hFFFF_FFFF);
        bus_write(12'h036, 32'hFFFF_FFFF);
        bus_write(12'h200, 32'hFFFF_FFFF);
        check("R10 pin_out after stray writes", 64'(pin_out), 64'hFEFF_8000_0100);
        check("R10 pin_oe after stray writes", 64'(pin_oe), 64'hFFFF_0000_FF0F);
        bus_read(12'h054, d);
        check("R10 past last bank reads zero", 64'(d), 64'h0);
        bus_read(12'h006, d);
        check("R10 misaligned reads zero", 64'(d), 64'h0);

        // Synchroniser latency
        @(negedge clk);
        pin_in = 48'hA5A5_1234_5678;
        addr = 12'h004; rd_en = 1'b1;
        @(negedge clk);
        check("R6 level at change edge", 64'(rd_data), 64'h0);
        @(negedge clk);
        check("R6 level one edge later", 64'(rd_data), 64'h0);
        @(negedge clk);
        check("R6 level two edges later", 64'(rd_data), 64'h1234_5678);
        rd_en = 1'b0;
        @(negedge clk);
        check("R9 idle read port", 64'(rd_data), 64'h0);

        bus_read(12'h008, d);
        check("R11 level bank1 upper bits", 64'(d), 64'h0000_A5A5);
        bus_write(12'h004, 32'h0000_0000);
        bus_read(12'h004, d);
        check("R7 level write ignored", 64'(d), 64'h1234_5678);
        check("R7 outputs after level write", 64'(pin_out), 64'hFEFF_8000_0100);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule